// File: doc/BRIEF.md
# Burst Bus Initiator with Master-Abort Timeout

This block is the initiator side of a multiplexed address/data parallel bus. A local requester hands it a read or write of one or more 32-bit beats at a start address. The block then runs the bus sequence. It drives an address phase carrying the command code. On reads it inserts one turnaround cycle. It then runs data phases with per-beat byte enables and ends with an orderly final phase. Bus controls are modelled as active-high internal signals: frame, initiator-ready, target device-select, target-ready and target-stop.

The local side supplies write data and byte enables combinationally for the beat index that the block presents. It receives one read-data pulse per completed read beat. At the end it gets a single completion pulse with a status code and the number of beats that moved. A target that never claims the cycle is detected by a timeout. The block then ends the transaction with all-ones read data or a silently dropped write. A target stop ends the transaction early, and the block reports whether that was a retry or a disconnect.

Top module: `pbus_initiator`

## Requirements
- R1: A request is accepted only on a clock where `req_ready` is high. In the next cycle frame is high, initiator-ready is low, the address is driven on `bus_ad_out` with `bus_ad_oe` high, and `bus_cbe` carries the command: 4'b0110 for a read and 4'b0111 for a write.
- R2: A write enters its first data phase (initiator-ready high) in the cycle right after the address phase. A read spends that cycle in turnaround, with initiator-ready low and `bus_ad_oe` low.
- R3: A beat moves only at a clock edge where initiator-ready, target-ready and device-select are all high. During a write beat, `bus_ad_out` and `bus_cbe` equal `wr_data` and `beat_be` for beat index `wr_beat`, counted from 0. Each read beat gives one `rd_valid` pulse in the next cycle, carrying the sampled `bus_ad_in`, in beat order.
- R4: In every data phase, frame is high exactly when the current beat is not the last requested one. Frame therefore drops together with the last beat's initiator-ready.
- R5: Every transaction ends with one cycle of frame low and initiator-ready high, followed by a cycle with both low. `done` pulses for one clock in that idle cycle. Initiator-ready never falls while frame is high.
- R6: If device-select is not sampled high in any of the five clocks after the address phase, the block aborts. Frame goes low first and initiator-ready follows one clock later. `done` arrives 6 cycles after the address cycle for a single-beat request and 7 for a longer one, with `done_code` 3 and `done_beats` 0.
- R7: An aborted read returns exactly one `rd_valid` pulse, with data 32'hFFFF_FFFF, in the `done` cycle. An aborted write gives no `rd_valid` and is not retried: frame stays low in the cycle after `done`.
- R8: Device-select first sampled high on the fourth clock after the address phase still counts as a claim, and the transaction completes normally.
- R9: When stop is sampled while frame is high, frame is low in the next cycle. A stop before the requested count is reached gives `done_code` 1 (retry) if no beat moved, and 2 (disconnect) otherwise. A beat with target-ready high on the stop clock counts.
- R10: A transaction that moves all requested beats reports `done_code` 0 and `done_beats` equal to the requested length (1 to 2^LEN_W-1). This holds even when stop coincides with the last beat.
- R11: After reset, frame, initiator-ready, `bus_ad_oe`, `done` and `rd_valid` are low and `req_ready` is high. `req_ready` is high only while the bus is idle.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Start address |
| req_len | input | LEN_W | Number of beats |
| req_ready | output | 1 | Block idle, request can be taken |
| wr_beat | output | LEN_W | Index of the beat whose write data is needed |
| wr_data | input | 32 | Write data for beat `wr_beat` |
| beat_be | input | 4 | Byte enables for beat `wr_beat` |
| rd_valid | output | 1 | Read beat (or abort fill) valid |
| rd_data | output | 32 | Read data |
| done | output | 1 | Transaction finished (one clock) |
| done_code | output | 2 | 0 ok, 1 retry, 2 disconnect, 3 abort |
| done_beats | output | LEN_W | Beats moved |
| bus_frame | output | 1 | Frame (active high) |
| bus_irdy | output | 1 | Initiator ready (active high) |
| bus_ad_out | output | 32 | Address/data driven value |
| bus_ad_oe | output | 1 | Address/data drive enable |
| bus_cbe | output | 4 | Command / byte enables |
| bus_ad_in | input | 32 | Address/data sampled value |
| bus_devsel | input | 1 | Target claims the cycle |
| bus_trdy | input | 1 | Target ready |
| bus_stop | input | 1 | Target requests termination |

## Verification
The bench acts as a target. It varies the device-select delay from 1 to 4 clocks or withholds it, and inserts random target-ready wait states. This separates normal completion from the abort path, and the abort timing for single-beat requests from multi-beat ones. Stop is placed on chosen beats, with and without target-ready. This tells retry from disconnect, and a stop on the last beat from one on an earlier beat. Reads and writes of lengths 1 to 8 tell apart the turnaround handling, frame release on the last beat, and beat ordering of data and byte enables.

// File: rtl/pbus_init_pkg.sv
package pbus_init_pkg;

    localparam int ADW = 32;
    localparam int CBW = ADW / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_TURN,
        ST_DATA,
        ST_ABORT,
        ST_QUIT
    } ini_state_e;

    typedef enum logic [1:0] {
        END_OK    = 2'd0,
        END_RETRY = 2'd1,
        END_DISC  = 2'd2,
        END_ABORT = 2'd3
    } end_code_e;

    localparam logic [CBW-1:0] CMD_MEM_RD = 4'b0110;
    localparam logic [CBW-1:0] CMD_MEM_WR = 4'b0111;
    localparam logic [ADW-1:0] ABORT_FILL = '1;

    typedef struct packed {
        logic           wr;
        logic [ADW-1:0] addr;
    } ini_req_t;

    function automatic logic [CBW-1:0] cmd_for(input logic is_write);
        return is_write ? CMD_MEM_WR : CMD_MEM_RD;
    endfunction

    function automatic end_code_e early_end(input logic any_beat);
        return any_beat ? END_DISC : END_RETRY;
    endfunction

endpackage

// File: rtl/pbus_abort_timer.sv
module pbus_abort_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic watch,
    input  logic devsel,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (watch && !seen_q) begin
            if (devsel) begin
                seen_q <= 1'b1;
            end else if (cnt_q != LIM) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign expire = watch && !seen_q && !devsel && (cnt_q == LIM);

endmodule

// File: rtl/pbus_beat_tracker.sv
module pbus_beat_tracker #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             advance,
    output logic [LEN_W-1:0] count,
    output logic             on_last
);
    logic [LEN_W-1:0] last_q;
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            last_q <= (len_in == '0) ? '0 : len_in - 1'b1;
            cnt_q  <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count   = cnt_q;
    assign on_last = (cnt_q == last_q);

endmodule

// File: rtl/pbus_initiator.sv
module pbus_initiator
    import pbus_init_pkg::*;
#(
    parameter int LEN_W      = 5,
    parameter int ABORT_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ADW-1:0]   req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    output logic [LEN_W-1:0] wr_beat,
    input  logic [ADW-1:0]   wr_data,
    input  logic [CBW-1:0]   beat_be,
    output logic             rd_valid,
    output logic [ADW-1:0]   rd_data,
    output logic             done,
    output logic [1:0]       done_code,
    output logic [LEN_W-1:0] done_beats,
    output logic             bus_frame,
    output logic             bus_irdy,
    output logic [ADW-1:0]   bus_ad_out,
    output logic             bus_ad_oe,
    output logic [CBW-1:0]   bus_cbe,
    input  logic [ADW-1:0]   bus_ad_in,
    input  logic             bus_devsel,
    input  logic             bus_trdy,
    input  logic             bus_stop
);
    ini_state_e       st_q, st_d;
    ini_req_t         req_q;
    end_code_e        code_q, code_d;
    logic             done_q, done_d;
    logic             rdv_q, rdv_d;
    logic [ADW-1:0]   rdd_q, rdd_d;

    logic             accept;
    logic             in_data;
    logic             xfer_ok;
    logic             expire;
    logic             on_last;
    logic [LEN_W-1:0] beat_cnt;

    assign accept  = (st_q == ST_IDLE) && req_valid;
    assign in_data = (st_q == ST_DATA);
    assign xfer_ok = in_data && bus_trdy && bus_devsel && !expire;

    pbus_abort_timer #(
        .LIMIT (ABORT_CLKS)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .arm    (st_q == ST_ADDR),
        .watch  ((st_q == ST_TURN) || in_data),
        .devsel (bus_devsel),
        .expire (expire)
    );

    pbus_beat_tracker #(
        .LEN_W (LEN_W)
    ) beats_i (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .len_in  (req_len),
        .advance (xfer_ok),
        .count   (beat_cnt),
        .on_last (on_last)
    );

    always_comb begin
        st_d   = st_q;
        code_d = code_q;
        done_d = 1'b0;
        rdv_d  = 1'b0;
        rdd_d  = rdd_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) st_d = ST_ADDR;
            end
            ST_ADDR: begin
                st_d = req_q.wr ? ST_DATA : ST_TURN;
            end
            ST_TURN: begin
                if (expire) begin
                    st_d   = ST_ABORT;
                    code_d = END_ABORT;
                end else begin
                    st_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (expire) begin
                    code_d = END_ABORT;
                    if (on_last) begin
                        st_d   = ST_IDLE;
                        done_d = 1'b1;
                        rdv_d  = !req_q.wr;
                        rdd_d  = ABORT_FILL;
                    end else begin
                        st_d = ST_ABORT;
                    end
                end else if (xfer_ok) begin
                    rdv_d = !req_q.wr;
                    rdd_d = bus_ad_in;
                    if (on_last) begin
                        st_d   = ST_IDLE;
                        done_d = 1'b1;
                        code_d = END_OK;
                    end else if (bus_stop) begin
                        st_d   = ST_QUIT;
                        code_d = END_DISC;
                    end
                end else if (bus_stop) begin
                    code_d = early_end(beat_cnt != '0);
                    if (on_last) begin
                        st_d   = ST_IDLE;
                        done_d = 1'b1;
                    end else begin
                        st_d = ST_QUIT;
                    end
                end
            end
            ST_ABORT: begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
                rdv_d  = !req_q.wr;
                rdd_d  = ABORT_FILL;
            end
            ST_QUIT: begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            req_q  <= '0;
            code_q <= END_OK;
            done_q <= 1'b0;
            rdv_q  <= 1'b0;
            rdd_q  <= '0;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
            done_q <= done_d;
            rdv_q  <= rdv_d;
            rdd_q  <= rdd_d;
            if (accept) begin
                req_q.wr   <= req_write;
                req_q.addr <= req_addr;
            end
        end
    end

    // Bus-side controls decoded from the phase
    assign bus_frame  = (st_q == ST_ADDR) || (st_q == ST_TURN) || (in_data && !on_last);
    assign bus_irdy   = in_data || (st_q == ST_ABORT) || (st_q == ST_QUIT);
    assign bus_ad_oe  = (st_q == ST_ADDR) ||
                        (req_q.wr && (in_data || (st_q == ST_ABORT) || (st_q == ST_QUIT)));
    assign bus_ad_out = (st_q == ST_ADDR) ? req_q.addr : wr_data;
    assign bus_cbe    = (st_q == ST_ADDR) ? cmd_for(req_q.wr) :
                        (st_q == ST_IDLE) ? '0 : beat_be;

    // Local-side results
    assign req_ready  = (st_q == ST_IDLE);
    assign wr_beat    = beat_cnt;
    assign rd_valid   = rdv_q;
    assign rd_data    = rdd_q;
    assign done       = done_q;
    assign done_code  = code_q;
    assign done_beats = done_q ? beat_cnt : '0;

endmodule

// File: rtl/pbus_initiator_chk.sv
module pbus_initiator_chk #(
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [31:0]      req_addr,
    input logic             done,
    input logic [1:0]       done_code,
    input logic [LEN_W-1:0] done_beats,
    input logic             rd_valid,
    input logic             bus_frame,
    input logic             bus_irdy,
    input logic             bus_ad_oe,
    input logic [31:0]      bus_ad_out,
    input logic             bus_trdy,
    input logic             bus_stop
);
    // R11
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_frame && !bus_irdy));

    // R1
    addr_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (bus_frame && !bus_irdy && bus_ad_oe &&
                                      bus_ad_out == $past(req_addr)));

    // R2
    rd_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> ##1 (!bus_irdy && !bus_ad_oe));

    // R2
    wr_nowait_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> ##1 bus_irdy);

    // R5
    irdy_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_irdy) |-> !$past(bus_frame));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_frame && !bus_irdy && $past(bus_irdy) && !$past(bus_frame)));

    // R3
    rdv_source_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(bus_irdy && bus_trdy) || done));

    // R9
    stop_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_stop && bus_frame && bus_irdy) |=> !bus_frame);

    // R6
    abort_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && done_code == 2'd3) |-> (done_beats == '0));

    // R4
    frame_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_frame) |-> !bus_irdy);

endmodule

bind pbus_initiator pbus_initiator_chk #(.LEN_W(LEN_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .done       (done),
    .done_code  (done_code),
    .done_beats (done_beats),
    .rd_valid   (rd_valid),
    .bus_frame  (bus_frame),
    .bus_irdy   (bus_irdy),
    .bus_ad_oe  (bus_ad_oe),
    .bus_ad_out (bus_ad_out),
    .bus_trdy   (bus_trdy),
    .bus_stop   (bus_stop)
);

// File: tb/pbus_initiator_tb_top.sv
module pbus_initiator_tb_top;
    localparam int LEN_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [31:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_ready;
    logic [LEN_W-1:0] wr_beat;
    logic [31:0]      wr_data;
    logic [3:0]       beat_be;
    logic             rd_valid;
    logic [31:0]      rd_data;
    logic             done;
    logic [1:0]       done_code;
    logic [LEN_W-1:0] done_beats;
    logic             bus_frame, bus_irdy, bus_ad_oe;
    logic [31:0]      bus_ad_out;
    logic [3:0]       bus_cbe;
    logic [31:0]      bus_ad_in = '0;
    logic             bus_devsel = 1'b0, bus_trdy = 1'b0, bus_stop = 1'b0;

    int checks = 0;
    int errors = 0;
    int tag = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [31:0] wdat_f(input int t, input int b);
        return 32'hA500_0000 ^ (32'(t) << 8) ^ (32'(b) * 32'h0101_0011);
    endfunction
    function automatic logic [3:0] be_f(input int t, input int b);
        return 4'(t + 3 * b) ^ 4'h5;
    endfunction
    function automatic logic [31:0] rdat_f(input int t, input int b);
        return 32'h3C00_0000 ^ (32'(t) << 12) ^ (32'(b) * 32'h0011_0101);
    endfunction

    assign wr_data = wdat_f(tag, int'(wr_beat));
    assign beat_be = be_f(tag, int'(wr_beat));

    pbus_initiator #(.LEN_W(LEN_W), .ABORT_CLKS(4)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
        .wr_beat(wr_beat), .wr_data(wr_data), .beat_be(beat_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .done_code(done_code), .done_beats(done_beats),
        .bus_frame(bus_frame), .bus_irdy(bus_irdy), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_cbe(bus_cbe), .bus_ad_in(bus_ad_in),
        .bus_devsel(bus_devsel), .bus_trdy(bus_trdy), .bus_stop(bus_stop)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One transaction against a modelled target.
    // dsel: clocks after address phase until device-select (0 = never).
    // stop_at: beat count at which stop is raised (-1 = none).
    task automatic run_txn(input bit wr, input logic [31:0] addr, input int len,
                           input int dsel, input int stop_at, input bit stop_data,
                           input int wait_pct);
        logic [31:0] exp_rd [0:31];
        logic [31:0] got_rd [0:31];
        int ngot = 0;
        int xfers = 0;
        int c = 0;
        int done_c = -1;
        bit hold = 1'b0;
        bit stopped = 1'b0;
        bit pf = 1'b0, pi = 1'b0;
        logic [1:0] code_seen = '0;
        logic [LEN_W-1:0] beats_seen = '0;
        int exp_code;
        tag++;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_frame && !bus_irdy && bus_ad_oe && bus_ad_out == addr, "R1",
            "address phase ad", bus_ad_out, addr);
        chk(bus_cbe == (wr ? 4'b0111 : 4'b0110), "R1", "command code",
            32'(bus_cbe), wr ? 32'd7 : 32'd6);
        while (done_c < 0 && c < 60) begin
            if (c == 1) begin
                if (wr) chk(bus_irdy == 1'b1, "R2", "write data phase at once", 32'(bus_irdy), 32'd1);
                else    chk(!bus_irdy && !bus_ad_oe, "R2", "read turnaround",
                            {30'd0, bus_irdy, bus_ad_oe}, 32'd0);
            end
            bus_devsel = (dsel != 0) && (c >= dsel);
            bus_trdy = 1'b0;
            bus_ad_in = rdat_f(tag, xfers);
            if (hold) begin
                bus_stop = bus_frame;
            end else if (bus_devsel && bus_irdy) begin
                if (stop_at == xfers) begin
                    bus_stop = 1'b1;
                    bus_trdy = stop_data;
                    hold = 1'b1;
                    stopped = 1'b1;
                end else begin
                    bus_trdy = (($urandom % 100) >= wait_pct);
                end
            end
            if (bus_irdy && bus_trdy && bus_devsel) begin
                chk(bus_frame == (xfers < len - 1), "R4", "frame vs last beat",
                    32'(bus_frame), 32'(xfers < len - 1));
                if (wr) begin
                    chk(bus_ad_out == wdat_f(tag, xfers) && bus_ad_oe, "R3", "write beat data",
                        bus_ad_out, wdat_f(tag, xfers));
                    chk(bus_cbe == be_f(tag, xfers), "R3", "write beat enables",
                        32'(bus_cbe), 32'(be_f(tag, xfers)));
                end else begin
                    exp_rd[xfers] = rdat_f(tag, xfers);
                end
                xfers++;
            end
            pf = bus_frame; pi = bus_irdy;
            @(negedge clk);
            c++;
            if (rd_valid && ngot < 32) begin
                got_rd[ngot] = rd_data;
                ngot++;
            end
            if (done) begin
                done_c = c;
                code_seen = done_code;
                beats_seen = done_beats;
                chk(!bus_frame && !bus_irdy && !pf && pi, "R5", "final phase then idle",
                    {28'd0, bus_frame, bus_irdy, pf, pi}, 32'd1);
            end
        end
        bus_devsel = 1'b0; bus_trdy = 1'b0; bus_stop = 1'b0;
        chk(done_c >= 0, "R5", "done seen", 32'(done_c), 32'd0);
        if (dsel == 0) begin
            chk(done_c == ((len > 1) ? 7 : 6), "R6", "abort done cycle",
                32'(done_c), (len > 1) ? 32'd7 : 32'd6);
            chk(code_seen == 2'd3 && beats_seen == '0, "R6", "abort status",
                {code_seen, 24'd0, 3'd0, beats_seen}, 32'hC000_0000);
            if (wr) begin
                chk(ngot == 0, "R7", "no read data on aborted write", 32'(ngot), 32'd0);
                @(negedge clk);
                chk(!bus_frame && req_ready, "R7", "aborted write not retried", 32'(bus_frame), 32'd0);
            end else begin
                chk(ngot == 1 && got_rd[0] == 32'hFFFF_FFFF, "R7", "abort read fill",
                    (ngot > 0) ? got_rd[0] : 32'd0, 32'hFFFF_FFFF);
            end
        end else begin
            if (xfers == len) exp_code = 0;
            else exp_code = (xfers == 0) ? 1 : 2;
            chk(code_seen == 2'(exp_code), (exp_code == 0) ? "R10" : "R9",
                "done code", 32'(code_seen), 32'(exp_code));
            chk(beats_seen == LEN_W'(xfers), (stopped && xfers < len) ? "R9" : "R10",
                "done beats", 32'(beats_seen), 32'(xfers));
            if (dsel == 4 && !stopped)
                chk(code_seen == 2'd0, "R8", "late claim not aborted", 32'(code_seen), 32'd0);
            if (!wr) begin
                chk(ngot == xfers, "R3", "read beat count", 32'(ngot), 32'(xfers));
                for (int i = 0; i < xfers && i < ngot; i++)
                    chk(got_rd[i] == exp_rd[i], "R3", "read beat data", got_rd[i], exp_rd[i]);
            end else begin
                chk(ngot == 0, "R3", "no read pulses on write", 32'(ngot), 32'd0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!bus_frame && !bus_irdy && !bus_ad_oe && !done && !rd_valid && req_ready,
            "R11", "reset state", {26'd0, bus_frame, bus_irdy, bus_ad_oe, done, rd_valid, req_ready},
            32'd1);
        // directed corners
        run_txn(1'b1, 32'h1000_0040, 1, 1, -1, 1'b0, 0);   // R10 single write
        run_txn(1'b0, 32'h2000_0100, 4, 2, -1, 1'b0, 30);  // R10 burst read
        run_txn(1'b0, 32'h2000_0200, 3, 4, -1, 1'b0, 0);   // R8 claim on 4th clock
        run_txn(1'b1, 32'h2000_0300, 1, 4, -1, 1'b0, 0);   // R8 single write late claim
        run_txn(1'b1, 32'h3000_0000, 3, 0, -1, 1'b0, 0);   // R6 R7 aborted write
        run_txn(1'b0, 32'h3000_0010, 1, 0, -1, 1'b0, 0);   // R6 R7 aborted single read
        run_txn(1'b0, 32'h3000_0020, 2, 0, -1, 1'b0, 0);   // R6 aborted burst read
        run_txn(1'b0, 32'h4000_0000, 4, 1, 0, 1'b0, 0);    // R9 retry
        run_txn(1'b1, 32'h4000_0100, 5, 1, 2, 1'b1, 0);    // R9 disconnect with data
        run_txn(1'b1, 32'h4000_0200, 4, 2, 2, 1'b0, 0);    // R9 disconnect without data
        run_txn(1'b0, 32'h4000_0300, 3, 1, 2, 1'b1, 0);    // R10 stop on last beat
        run_txn(1'b1, 32'h4000_0400, 2, 3, 1, 1'b0, 0);    // R9 stop when frame already low
        // constrained random mix
        for (int n = 0; n < 40; n++) begin
            int len = 1 + int'($urandom % 8);
            int dsel = (($urandom % 6) == 0) ? 0 : 1 + int'($urandom % 4);
            int sa = (($urandom % 4) == 0) ? int'($urandom % len) : -1;
            run_txn(1'($urandom), $urandom & 32'hFFFF_FFFC, len, dsel, sa,
                    1'($urandom), int'($urandom % 50));
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule